// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block turns the pins of one GPIO port into interrupts. Every line has its own configuration bits. One bit picks level or edge sensing. A second bit picks the active polarity. A third bit enables the line, and a fourth places a debounce filter in front of the detector. Edge events are caught in sticky pending bits. Software clears them by writing ones to an acknowledge register.

The pins arrive already synchronised to the clock. The debounce filter advances only on a separate sampling strobe. The block drives one output bit per line and a combined request output. Software can detect both edges of a signal by flipping a line's polarity bit after each acknowledge. The detector is built so that such a flip never produces an event by itself.

Registers sit on a plain byte-addressed write port with a combinational read port. The offsets are fixed so that existing driver code can find them.

Top module: `gpio_port_irq`

## Requirements
- R1: Reset sets every configuration register and every pending bit to zero. `irq_o` and `line_irq_o` are then low. After reset, the registers read back what was written at these byte offsets: sense kind at 0x00, polarity at 0x04, enable at 0x0C, debounce enable at 0x18. The acknowledge offset 0x08 reads as zero.
- R2: A line whose sense-kind bit is 0 is level sensitive, and its status bit follows the live filtered input. With polarity bit 1 it is active while the input is high; with polarity bit 0 it is active while the input is low.
- R3: A line whose sense-kind bit is 1 is edge sensitive. Polarity bit 1 selects rising edges and 0 selects falling edges. A matching edge sets the line's pending bit at the clock edge after it is seen. The bit stays set until it is acknowledged, whatever the input does next.
- R4: Writing to offset 0x08 clears the pending bit of every line whose data bit is 1. Data bits that are 0 leave their lines untouched.
- R5: If an acknowledge and a new matching edge on the same line fall in the same clock cycle, the new edge wins and the pending bit stays set.
- R6: A line with enable bit 0 drives a status bit of 0. Edges that occur while it is disabled are not latched, so enabling the line later raises nothing.
- R7: Changing a line's polarity bit while its input is steady never sets its pending bit.
- R8: When a line's debounce bit is 1, its filtered input takes a new value only after the raw pin has differed from the filtered value on 3 consecutive sampling strobes. A shorter excursion is discarded.
- R9: Status, read at offset 0x10 (read-only), is the per-line result of R2, R3 and R6. `line_irq_o` carries the status bits one per line, and `irq_o` is their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register byte offset |
| bus_wdata_i | input | 8 | Write data, one bit per line |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| pins_i | input | 8 | Synchronised pin levels |
| sample_stb_i | input | 1 | Debounce sampling strobe |
| irq_o | output | 1 | Combined interrupt request |
| line_irq_o | output | 8 | Per-line interrupt requests |

## Verification
An acknowledge and a fresh edge on the same line can land in the same clock cycle. The bench provokes this by driving the rising pin in the very cycle that the acknowledge write for that line is on the bus. It then expects the status bit to read as set afterwards, not cleared. A polarity flip on a steady input is also tried just after an acknowledge, to show that the both-edge procedure cannot create an event by itself.

// File: rtl/gpio_port_irq.sv
module gpio_port_irq #(
  parameter int LINES    = 8,
  parameter int DB_COUNT = 3,
  parameter int AW       = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_wr_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [LINES-1:0] bus_wdata_i,
  output logic [LINES-1:0] bus_rdata_o,
  input  logic [LINES-1:0] pins_i,
  input  logic             sample_stb_i,
  output logic             irq_o,
  output logic [LINES-1:0] line_irq_o
);
  localparam int CW = $clog2(DB_COUNT + 1);
  localparam logic [AW-1:0] A_KIND = AW'(8'h00);
  localparam logic [AW-1:0] A_POL  = AW'(8'h04);
  localparam logic [AW-1:0] A_ACK  = AW'(8'h08);
  localparam logic [AW-1:0] A_EN   = AW'(8'h0C);
  localparam logic [AW-1:0] A_STAT = AW'(8'h10);
  localparam logic [AW-1:0] A_DB   = AW'(8'h18);

  logic [LINES-1:0] kind_q, pol_q, en_q, dben_q, pend_q, prev_q, deb_q;
  logic [LINES-1:0] filt, hit, lvl, status, ack;

  assign ack    = (bus_wr_i && bus_addr_i == A_ACK) ? bus_wdata_i : '0;
  assign filt   = (dben_q & deb_q) | (~dben_q & pins_i);
  assign hit    = en_q & kind_q & ((pol_q & filt & ~prev_q) | (~pol_q & ~filt & prev_q));
  assign lvl    = ~(filt ^ pol_q);
  assign status = en_q & ((kind_q & pend_q) | (~kind_q & lvl));

  assign line_irq_o = status;
  assign irq_o      = |status;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      kind_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      dben_q <= '0;
      pend_q <= '0;
      prev_q <= pins_i;
    end else begin
      if (bus_wr_i && bus_addr_i == A_KIND) kind_q <= bus_wdata_i;
      if (bus_wr_i && bus_addr_i == A_POL)  pol_q  <= bus_wdata_i;
      if (bus_wr_i && bus_addr_i == A_EN)   en_q   <= bus_wdata_i;
      if (bus_wr_i && bus_addr_i == A_DB)   dben_q <= bus_wdata_i;
      pend_q <= kind_q & ((pend_q & ~ack) | hit);
      prev_q <= filt;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_deb
    logic          d_q;
    logic [CW-1:0] c_q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni || !dben_q[i] || pins_i[i] == d_q) begin
        d_q <= pins_i[i];
        c_q <= '0;
      end else if (sample_stb_i) begin
        if (c_q == CW'(DB_COUNT - 1)) begin
          d_q <= pins_i[i];
          c_q <= '0;
        end else begin
          c_q <= c_q + 1'b1;
        end
      end
    end
    assign deb_q[i] = d_q;
  end

  always_comb begin
    case (bus_addr_i)
      A_KIND:  bus_rdata_o = kind_q;
      A_POL:   bus_rdata_o = pol_q;
      A_EN:    bus_rdata_o = en_q;
      A_STAT:  bus_rdata_o = status;
      A_DB:    bus_rdata_o = dben_q;
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

module gpio_port_irq_chk #(
  parameter int LINES = 8,
  parameter int AW    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_wr_i,
  input logic [AW-1:0]    bus_addr_i,
  input logic [LINES-1:0] bus_wdata_i,
  input logic             sample_stb_i,
  input logic             irq_o,
  input logic [LINES-1:0] line_irq_o,
  input logic [LINES-1:0] pend_q,
  input logic [LINES-1:0] hit,
  input logic [LINES-1:0] filt,
  input logic [LINES-1:0] en_q,
  input logic [LINES-1:0] dben_q
);
  AST_RESET_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (pend_q == '0)); // R1

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wr_i |=> (($past(pend_q) & ~pend_q) == '0)); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == AW'(8'h08)) |=>
      ((pend_q & $past(bus_wdata_i) & ~$past(hit)) == '0)); // R4

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_irq_o & ~en_q) == '0); // R6

  AST_DEB_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((filt ^ $past(filt)) & dben_q & $past(dben_q)) != '0) |-> $past(sample_stb_i)); // R8

  AST_IRQ_HAS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($countones(line_irq_o) >= 1)); // R9
endmodule

bind gpio_port_irq gpio_port_irq_chk #(.LINES(LINES), .AW(AW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .sample_stb_i(sample_stb_i), .irq_o(irq_o),
  .line_irq_o(line_irq_o), .pend_q(pend_q), .hit(hit), .filt(filt),
  .en_q(en_q), .dben_q(dben_q)
);

// File: tb/gpio_port_irq_tb_top.sv
module gpio_port_irq_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_wr_i = 1'b0;
  logic [4:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic [7:0] pins_i = '0;
  logic       sample_stb_i = 1'b0;
  logic       irq_o;
  logic [7:0] line_irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #5 clk_i = ~clk_i;

  gpio_port_irq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .pins_i(pins_i),
    .sample_stb_i(sample_stb_i), .irq_o(irq_o), .line_irq_o(line_irq_o)
  );

  localparam logic [4:0] KIND = 5'h00, POL = 5'h04, ACK = 5'h08,
                         EN = 5'h0C, STAT = 5'h10, DB = 5'h18;

  initial begin : monitor
    forever begin
      @(posedge clk_i);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = q.pop_front();
        case (it.kind)
          0: got = bus_rdata_o;
          1: got = line_irq_o;
          default: got = {7'd0, irq_o};
        endcase
        total++;
        if (got !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%02h expected=%02h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic expect_item(input int k, input logic [4:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk_i);
    bus_addr_i = a;
    it.kind = k; it.exp = e; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
    expect_item(0, a, e, tag);
  endtask

  task automatic pins(input logic [7:0] v);
    @(negedge clk_i);
    pins_i = v;
    idle(2);
  endtask

  task automatic strobe(input int n);
    repeat (n) begin
      @(negedge clk_i); sample_stb_i = 1'b1;
      @(negedge clk_i); sample_stb_i = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    idle(3);
    rst_ni = 1'b1;
    // R1 reset state
    rd(KIND, 8'h00, "R1 kind reset");
    rd(EN, 8'h00, "R1 enable reset");
    rd(STAT, 8'h00, "R1 status reset");
    expect_item(2, STAT, 8'h00, "R1 irq reset");
    // R1 readback and map
    wr(KIND, 8'hA5); wr(POL, 8'h3C); wr(DB, 8'h81);
    rd(KIND, 8'hA5, "R1 kind readback");
    rd(POL, 8'h3C, "R1 polarity readback");
    rd(DB, 8'h81, "R1 debounce readback");
    rd(ACK, 8'h00, "R1 ack reads zero");
    wr(STAT, 8'hFF);
    rd(STAT, 8'h00, "R9 status read-only");
    wr(KIND, 8'h00); wr(POL, 8'h00); wr(DB, 8'h00);
    // R2 level sensing: line0 high-active, line1 low-active
    wr(POL, 8'h01); wr(EN, 8'h03);
    pins(8'h00);
    rd(STAT, 8'h02, "R2 low level active");
    pins(8'h03);
    rd(STAT, 8'h01, "R2 high level active");
    expect_item(1, STAT, 8'h01, "R9 line outputs level");
    expect_item(2, STAT, 8'h01, "R9 irq level");
    // R3 rising edge on line2
    wr(EN, 8'h00); wr(KIND, 8'h04); wr(POL, 8'h04); pins(8'h00); wr(EN, 8'h04);
    rd(STAT, 8'h00, "R3 idle before edge");
    pins(8'h04);
    rd(STAT, 8'h04, "R3 rising latched");
    pins(8'h00);
    rd(STAT, 8'h04, "R3 sticky after input drops");
    expect_item(1, STAT, 8'h04, "R9 line output edge");
    wr(ACK, 8'h00);
    rd(STAT, 8'h04, "R4 zero ack no effect");
    wr(ACK, 8'h04);
    rd(STAT, 8'h00, "R4 ack clears");
    expect_item(2, STAT, 8'h00, "R9 irq after ack");
    // R3 falling edge on line3
    wr(EN, 8'h00); wr(KIND, 8'h08); wr(POL, 8'h00); wr(EN, 8'h08);
    pins(8'h08);
    rd(STAT, 8'h00, "R3 rising ignored on falling line");
    pins(8'h00);
    rd(STAT, 8'h08, "R3 falling latched");
    wr(ACK, 8'h08);
    // R6 disabled line latches nothing
    wr(EN, 8'h00); wr(KIND, 8'h04); wr(POL, 8'h04);
    pins(8'h04);
    rd(STAT, 8'h00, "R6 disabled status");
    expect_item(2, STAT, 8'h00, "R6 disabled irq");
    wr(EN, 8'h04);
    rd(STAT, 8'h00, "R6 no latch while disabled");
    pins(8'h00);
    // R5 edge and ack in the same cycle
    @(negedge clk_i);
    pins_i = 8'h04; bus_wr_i = 1'b1; bus_addr_i = ACK; bus_wdata_i = 8'h04;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
    rd(STAT, 8'h04, "R5 set wins over ack");
    wr(ACK, 8'h04);
    rd(STAT, 8'h00, "R5 later ack clears");
    // R7 polarity flip on steady input
    wr(POL, 8'h00);
    idle(2);
    rd(STAT, 8'h00, "R7 flip no spurious edge");
    pins(8'h00);
    rd(STAT, 8'h04, "R7 falling after flip");
    wr(ACK, 8'h04);
    // R8 debounce on line4
    wr(EN, 8'h00); wr(KIND, 8'h10); wr(POL, 8'h10); wr(DB, 8'h10); wr(EN, 8'h10);
    pins(8'h10);
    rd(STAT, 8'h00, "R8 no change without strobes");
    strobe(2); idle(2);
    rd(STAT, 8'h00, "R8 two strobes not enough");
    strobe(1); idle(3);
    rd(STAT, 8'h10, "R8 third strobe passes");
    wr(ACK, 8'h10); wr(POL, 8'h00);
    idle(2);
    rd(STAT, 8'h00, "R7 flip with debounce");
    pins(8'h00); strobe(2);
    pins(8'h10); strobe(3); idle(3);
    rd(STAT, 8'h00, "R8 short glitch discarded");
    pins(8'h00); strobe(3); idle(3);
    rd(STAT, 8'h10, "R8 debounced falling edge");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule